// File: doc/BRIEF.md
# Odd-Line Inversion Link Encoder and Decoder

This block codes flits for one point-to-point network-on-chip link so that the wires switch less, and counts coupling as well as self switching. On the transmit side it sits in the network interface. It takes payload flits of W-1 bits through a valid/ready handshake and places them in a registered W-bit link word. The extra wire carries an inversion flag. For each body flit the encoder works out a cost for two forms of the word: the payload as it is, or the payload with every odd-indexed bit inverted. Each cost is measured against the word last driven on the link, and the cheaper form is sent. Header flits are never coded, so routers can read them directly.

The cost of a candidate word has two parts. One counts the lines that rise from 0 to 1. The other adds a weight for every neighbouring pair of lines, the flag line included. When only one line of the pair toggles, the weight is 1. When both toggle in opposite directions, the weight is 2. When both toggle the same way, or neither moves, the weight is 0. On the receive side a decoder with no memory restores the payload from the flag alone. It can be built purely combinational or with one output register.

Top module: `link_codec`

## Requirements
- R1: The link word places the inversion flag at bit W-1 and the payload at bits W-2..0. A header flit (in_head=1) is always sent with flag 0 and its payload unchanged.
- R2: A body flit is sent with every odd-indexed payload bit inverted (mask bits 1,3,5,...) and flag 1, but only when that form's cost is strictly lower than the cost of the unchanged form with flag 0. If the costs are equal, the unchanged form is sent.
- R3: The cost of a candidate word against the previous link word is the sum of two counts over all W lines. The first counts lines that go 0 to 1. The second adds a weight for each adjacent pair (i, i+1): 1 if exactly one of the two toggles, 2 if both toggle to different new values, and 0 otherwise.
- R4: The previous-word reference is the word currently held on the link. It is zero after reset and changes only when an input handshake completes. Header flits update it as well.
- R5: A flit accepted at a clock edge (in_valid and in_ready both high) appears on link_data with link_valid high right after that edge. This is one cycle of latency.
- R6: in_ready is low while link_valid is high and link_ready is low. During such a stall, link_data and link_valid hold their values. When a word is consumed and no new flit is accepted, link_valid falls and link_data keeps its value.
- R7: The decoder inverts the odd-indexed payload bits of rx_link_data when bit W-1 is high, and passes them through unchanged otherwise. It uses no history.
- R8: While reset is high, link_valid and link_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transmit flit valid |
| in_ready | output | 1 | Encoder can accept a flit |
| in_head | input | 1 | Flit is a packet header (bypasses coding) |
| in_data | input | W-1 | Transmit payload |
| link_valid | output | 1 | Link word valid |
| link_ready | input | 1 | Downstream accepts the link word |
| link_data | output | W | Coded link word, flag in the top bit |
| rx_link_data | input | W | Received link word |
| rx_payload | output | W-1 | Decoded payload |

## Verification
The bench drives several hand-worked patterns from a known all-zero reference. An all-zero payload tells apart a wrongly inverting encoder. An all-ones payload must stay plain, because inversion would cost 47 against 32. A fall of the odd lines after an all-ones word must be inverted, since inversion then costs 2 against 30. This last pattern separates the coupling-weighted rule from a rule that only counts rising lines. A header with the same payload checks the bypass. A long random stream with mixed headers is then compared against an independent cost model. This stream exercises the tie rule, both pair weights and the flag line's coupling. Every word also goes through the decoder to check the round trip. Stall and mid-stream reset tests show whether the reference word updates only on handshakes and returns to zero.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic [1:0] {
        PK_QUIET    = 2'd0,
        PK_SINGLE   = 2'd1,
        PK_SAME     = 2'd2,
        PK_OPPOSITE = 2'd3
    } pair_kind_e;

    localparam logic [63:0] ODD_PATTERN = 64'hAAAA_AAAA_AAAA_AAAA;

    function automatic pair_kind_e classify_pair(
        input logic prev_lo, input logic prev_hi,
        input logic cur_lo,  input logic cur_hi
    );
        logic tog_lo;
        logic tog_hi;
        tog_lo = prev_lo ^ cur_lo;
        tog_hi = prev_hi ^ cur_hi;
        if (tog_lo && tog_hi)
            return (cur_lo != cur_hi) ? PK_OPPOSITE : PK_SAME;
        else if (tog_lo || tog_hi)
            return PK_SINGLE;
        else
            return PK_QUIET;
    endfunction

    function automatic logic [1:0] pair_weight(input pair_kind_e k);
        case (k)
            PK_SINGLE:   return 2'd1;
            PK_OPPOSITE: return 2'd2;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/lc_cost.sv
module lc_cost #(
    parameter int W  = 32,
    parameter int CW = $clog2(3 * W)
) (
    input  logic [W-1:0]  prev_word,
    input  logic [W-1:0]  cand_word,
    output logic [CW-1:0] cost
);
    import lc_pkg::*;

    logic [W-1:0]   rise;
    logic [1:0]     pw [W-1];

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_self
            assign rise[g] = ~prev_word[g] & cand_word[g];
        end
        for (g = 0; g < W - 1; g++) begin : g_pair
            assign pw[g] = pair_weight(classify_pair(prev_word[g], prev_word[g+1],
                                                     cand_word[g], cand_word[g+1]));
        end
    endgenerate

    always_comb begin
        cost = '0;
        for (int i = 0; i < W; i++)
            cost = cost + CW'(rise[i]);
        for (int i = 0; i < W - 1; i++)
            cost = cost + CW'(pw[i]);
    end

endmodule

// File: rtl/lc_encoder.sv
module lc_encoder #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_head,
    input  logic [W-2:0] in_data,
    output logic         link_valid,
    input  logic         link_ready,
    output logic [W-1:0] link_data
);
    localparam int PW = W - 1;
    localparam int CW = $clog2(3 * W);
    localparam logic [PW-1:0] ODD_MASK = PW'(lc_pkg::ODD_PATTERN);

    logic [W-1:0]  word_q;
    logic          vld_q;
    logic [W-1:0]  cand_plain;
    logic [W-1:0]  cand_odd;
    logic [CW-1:0] cost_plain;
    logic [CW-1:0] cost_odd;
    logic          use_odd;
    logic          accept;

    assign cand_plain = {1'b0, in_data};
    assign cand_odd   = {1'b1, in_data ^ ODD_MASK};

    lc_cost #(.W(W), .CW(CW)) u_cost_plain (
        .prev_word (word_q),
        .cand_word (cand_plain),
        .cost      (cost_plain)
    );

    lc_cost #(.W(W), .CW(CW)) u_cost_odd (
        .prev_word (word_q),
        .cand_word (cand_odd),
        .cost      (cost_odd)
    );

    assign use_odd  = !in_head && (cost_odd < cost_plain);
    assign in_ready = !vld_q || link_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else if (accept) begin
            word_q <= use_odd ? cand_odd : cand_plain;
            vld_q  <= 1'b1;
        end else if (link_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign link_valid = vld_q;
    assign link_data  = word_q;

endmodule

// File: rtl/lc_decoder.sv
module lc_decoder #(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_word,
    output logic [W-2:0] payload
);
    localparam int PW = W - 1;
    localparam logic [PW-1:0] ODD_MASK = PW'(lc_pkg::ODD_PATTERN);

    logic [PW-1:0] restored;
    assign restored = rx_word[PW-1:0] ^ (rx_word[W-1] ? ODD_MASK : '0);

    generate
        if (OUT_REG) begin : g_reg
            logic [PW-1:0] pay_q;
            always_ff @(posedge clk) begin
                if (rst) pay_q <= '0;
                else     pay_q <= restored;
            end
            assign payload = pay_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign payload = restored;
        end
    endgenerate

endmodule

// File: rtl/link_codec.sv
module link_codec #(
    parameter int W       = 32,
    parameter bit DEC_REG = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_head,
    input  logic [W-2:0] in_data,
    output logic         link_valid,
    input  logic         link_ready,
    output logic [W-1:0] link_data,
    input  logic [W-1:0] rx_link_data,
    output logic [W-2:0] rx_payload
);

    lc_encoder #(.W(W)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_head    (in_head),
        .in_data    (in_data),
        .link_valid (link_valid),
        .link_ready (link_ready),
        .link_data  (link_data)
    );

    lc_decoder #(.W(W), .OUT_REG(DEC_REG)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .rx_word (rx_link_data),
        .payload (rx_payload)
    );

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_head,
    input logic [W-2:0] in_data,
    input logic         link_valid,
    input logic         link_ready,
    input logic [W-1:0] link_data
);
    localparam int PW = W - 1;
    localparam logic [PW-1:0] ODD_MASK = PW'(lc_pkg::ODD_PATTERN);

    logic [PW-1:0] undone;
    assign undone = link_data[PW-1:0] ^ (link_data[W-1] ? ODD_MASK : '0);

    AST_HEAD_PLAIN: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_head |=> link_data == {1'b0, $past(in_data)}); // R1

    AST_BODY_RECOVER: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_head |=> undone == $past(in_data)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(link_data)); // R4

    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> link_valid); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        link_valid && !link_ready |=> link_valid && $stable(link_data)); // R6

    AST_STALL_NOREADY: assert property (@(posedge clk) disable iff (rst)
        link_valid && !link_ready |-> !in_ready); // R6

endmodule

bind link_codec lc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_head    (in_head),
    .in_data    (in_data),
    .link_valid (link_valid),
    .link_ready (link_ready),
    .link_data  (link_data)
);

// File: tb/sim_link_codec.sv
module sim_link_codec;
    localparam int W = 32;
    localparam logic [30:0] MASK = 31'h2AAA_AAAA;

    // entry: {head, 32-bit data (low 31 used), expected link word}; run from reset
    localparam logic [64:0] VEC [5] = '{
        {1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {1'b0, 32'h5555_5555, 32'hFFFF_FFFF},
        {1'b1, 32'h5555_5555, 32'h5555_5555},
        {1'b0, 32'h5555_5555, 32'h5555_5555}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_head = 1'b0;
    logic [30:0]  in_data = '0;
    logic         link_valid;
    logic         link_ready = 1'b1;
    logic [31:0]  link_data;
    logic [30:0]  rx_payload;

    int tests = 0;
    int fails = 0;
    int ties  = 0;
    logic [31:0] ref_prev = '0;

    always #5 clk = ~clk;

    link_codec #(.W(W)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head), .in_data(in_data),
        .link_valid(link_valid), .link_ready(link_ready), .link_data(link_data),
        .rx_link_data(link_data), .rx_payload(rx_payload)
    );

    function automatic int ref_cost(logic [31:0] p, logic [31:0] c);
        int s = 0;
        for (int i = 0; i < 32; i++) if (!p[i] && c[i]) s++;
        for (int i = 0; i < 31; i++) begin
            bit ta = p[i] != c[i];
            bit tb = p[i+1] != c[i+1];
            if (ta && tb && (c[i] != c[i+1])) s += 2;
            else if (ta != tb) s += 1;
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_word(logic [31:0] p, logic h, logic [30:0] d);
        logic [31:0] a = {1'b0, d};
        logic [31:0] b = {1'b1, d ^ MASK};
        if (!h && ref_cost(p, b) < ref_cost(p, a)) return b;
        return a;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // send one flit with link_ready high; check link word and round trip
    task automatic send(logic h, logic [30:0] d, logic [31:0] exp, string req);
        @(negedge clk);
        in_valid = 1'b1; in_head = h; in_data = d;
        @(posedge clk); #1;
        check(req, link_data, exp);
        check("R5", {31'd0, link_valid}, 32'd1);
        check("R7", {1'b0, rx_payload}, {1'b0, d});
        ref_prev = exp;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8", link_data, 32'h0);
        check("R8", {31'd0, link_valid}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // table walk: hand-worked expectations (R1 header, R2/R3 costs)
        foreach (VEC[k]) begin
            send(VEC[k][64], VEC[k][62:32], VEC[k][31:0], VEC[k][64] ? "R1" : "R2/R3");
        end

        // link idle: word stays as reference (R4)
        repeat (2) @(posedge clk);
        #1;
        check("R4", link_data, ref_prev);
        check("R6", {31'd0, link_valid}, 32'd0);

        // random stream against independent cost model (R2, R3)
        for (int n = 0; n < 600; n++) begin
            logic h = ($urandom % 8) == 0;
            logic [30:0] d = 31'($urandom);
            logic [31:0] e = ref_word(ref_prev, h, d);
            if (!h && ref_cost(ref_prev, {1'b1, d ^ MASK}) == ref_cost(ref_prev, {1'b0, d}))
                ties++;
            send(h, d, e, "R3");
        end
        $display("[TB] equal-cost flits seen: %0d", ties);

        // stall: link_ready low keeps word and blocks input (R6)
        @(negedge clk); link_ready = 1'b0;
        send(1'b0, 31'h1234_5678, ref_word(ref_prev, 1'b0, 31'h1234_5678), "R2");
        @(negedge clk);
        in_valid = 1'b1; in_head = 1'b0; in_data = 31'h0F0F_0F0F;
        #1;
        check("R6", {31'd0, in_ready}, 32'd0);
        repeat (3) @(posedge clk);
        #1;
        check("R6", link_data, ref_prev);
        check("R6", {31'd0, link_valid}, 32'd1);
        @(negedge clk); link_ready = 1'b1;
        @(posedge clk); #1;
        check("R4", link_data, ref_word(ref_prev, 1'b0, 31'h0F0F_0F0F));
        ref_prev = link_data;
        @(negedge clk); in_valid = 1'b0;

        // mid-stream reset returns reference to zero (R8, R4)
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R8", link_data, 32'h0);
        @(negedge clk); rst = 1'b0;
        ref_prev = '0;
        send(1'b0, 31'h5555_5555, ref_word(32'h0, 1'b0, 31'h5555_5555), "R4");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule